// File: doc/BRIEF.md
# Write-in-progress status responder

This block produces the word a flash-style memory returns on reads while an internal program or erase is running. A command decoder upstream sends a one-cycle launch pulse, together with the operation type and, for a program, the word being written. A down-counter loaded from a per-operation cycle count stands in for the internal write time. While that counter runs, the block raises a busy flag, and every read returns a status word in place of array data.

The status word carries two indicator bits. The polarity bit carries the inverse of the programmed bit during a program, and reads 0 during any erase. The toggle bit changes value on each successive read. Once the counter expires, reads pass the array word through unchanged. A completed program therefore shows its true data, and a completed erase shows the all-ones content of the erased region. Array storage itself lives outside this block.

Top module: `wip_responder`

## Requirements
- R1: After a synchronous reset, `busy_o` is 0 and `rd_data_o` is all zeros.
- R2: A `start_i` pulse while idle raises `busy_o` at the next clock edge. `busy_o` then stays high for exactly the duration selected by `op_i`, counted in clock cycles: code 0 is a program (PROG_CYC), code 1 a sector erase (SECT_CYC), code 2 a block erase (BLK_CYC) and code 3 a chip erase (CHIP_CYC). `busy_o` falls on the clock after the counter runs out.
- R3: A `start_i` pulse while `busy_o` is high has no effect. The running operation keeps its type, its data and its end time.
- R4: During a program, a read returns bit 7 (POLL_BIT) as the inverse of bit 7 of the launched word. All other bits except bit 6 equal the launched word.
- R5: During any erase, a read returns bit 7 as 0. All bits other than bit 6 are 0.
- R6: Bit 6 (TGL_BIT) of a busy read is 0 on the first read after a launch and inverts on every further busy read. Clocks without a read strobe do not advance it.
- R7: A read while `busy_o` is low returns `arr_data_i` as sampled on the strobe cycle. Once an operation has finished, its indicator bits are therefore replaced by array data.
- R8: Every read result appears on `rd_data_o` one clock after the `rd_en_i` cycle. It holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle launch pulse from the command decoder |
| op_i | input | 2 | Operation type: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| wdata_i | input | DATA_W | Word being programmed, sampled with the launch |
| rd_en_i | input | 1 | Read strobe |
| arr_data_i | input | DATA_W | Array read word |
| busy_o | output | 1 | Internal operation in progress |
| rd_data_o | output | DATA_W | Registered read result |

## Verification
`busy_o` changes at the first edge that samples an accepted launch. It stays high for exactly the selected number of cycles. Each read result becomes visible one edge after its strobe. The bench drives inputs and compares outputs on the falling edge. A behavioural model advances on the rising edge, so each comparison sees the values registered at the preceding edge. Stimulus covers back-to-back reads, reads separated by idle clocks, reads in the last busy cycle and in the first idle cycle, a launch that coincides with a read, and a launch issued mid-operation.

// File: rtl/wip_pkg.sv
package wip_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wip_timer.sv
module wip_timer
  import wip_pkg::*;
#(
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 60,
  parameter int BLK_CYC  = 80,
  parameter int CHIP_CYC = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  op_e  op,
  output logic busy,
  output logic launch
);
  localparam int MAXC  = max2(max2(PROG_CYC, SECT_CYC), max2(BLK_CYC, CHIP_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dur;

  assign launch = start & ~busy;

  always_comb begin
    case (op)
      OP_PROG: dur = CNT_W'(PROG_CYC - 1);
      OP_SECT: dur = CNT_W'(SECT_CYC - 1);
      OP_BLK:  dur = CNT_W'(BLK_CYC - 1);
      default: dur = CNT_W'(CHIP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= dur;
    end
  end
endmodule

// File: rtl/wip_toggle.sv
module wip_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  output logic tgl
);
  always_ff @(posedge clk) begin
    if (rst)        tgl <= 1'b0;
    else if (clear) tgl <= 1'b0;
    else if (adv)   tgl <= ~tgl;
  end
endmodule

// File: rtl/wip_status_mux.sv
module wip_status_mux
  import wip_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  op_e               op,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              tgl,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic              prog_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= 1'b0;
      wd_q   <= '0;
    end else if (launch) begin
      prog_q <= (op == OP_PROG);
      wd_q   <= wdata;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_st
    if (b == POLL_BIT) begin : g_poll
      assign st[b] = prog_q & ~wd_q[b];
    end else if (b == TGL_BIT) begin : g_tgl
      assign st[b] = tgl;
    end else begin : g_pass
      assign st[b] = prog_q & wd_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= busy ? st : arr_data;
  end
endmodule

// File: rtl/wip_responder.sv
module wip_responder
  import wip_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 60,
  parameter int BLK_CYC  = 80,
  parameter int CHIP_CYC = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_data_o
);
  op_e  op;
  logic launch;
  logic tgl;

  assign op = op_e'(op_i);

  wip_timer #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .BLK_CYC(BLK_CYC),   .CHIP_CYC(CHIP_CYC)
  ) timer_i (
    .clk(clk), .rst(rst), .start(start_i), .op(op),
    .busy(busy_o), .launch(launch)
  );

  wip_toggle toggle_i (
    .clk(clk), .rst(rst), .clear(launch),
    .adv(rd_en_i & busy_o), .tgl(tgl)
  );

  wip_status_mux #(
    .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)
  ) mux_i (
    .clk(clk), .rst(rst), .launch(launch), .op(op), .wdata(wdata_i),
    .rd_en(rd_en_i), .busy(busy_o), .tgl(tgl),
    .arr_data(arr_data_i), .rd_data(rd_data_o)
  );
endmodule

// File: rtl/wip_responder_chk.sv
module wip_responder_chk
  import wip_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 60,
  parameter int BLK_CYC  = 80,
  parameter int CHIP_CYC = 150
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam int MAXC = max2(max2(PROG_CYC, SECT_CYC), max2(BLK_CYC, CHIP_CYC));

  logic  prog_q, d7_q, exp_tgl;
  int    run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= 1'b0;
      d7_q    <= 1'b0;
      exp_tgl <= 1'b0;
      run_len <= 0;
    end else begin
      run_len <= busy_o ? run_len + 1 : 0;
      if (start_i && !busy_o) begin
        prog_q  <= (op_i == 2'd0);
        d7_q    <= wdata_i[POLL_BIT];
        exp_tgl <= 1'b0;
      end else if (rd_en_i && busy_o) begin
        exp_tgl <= ~exp_tgl;
      end
    end
  end

  // R2: busy only rises after a launch pulse
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  // R2, R3: no run exceeds the longest duration, so no mid-run relaunch
  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_len < MAXC));
  assert_prog_poll_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && busy_o && prog_q) |=> (rd_data_o[POLL_BIT] == ~$past(d7_q)));
  assert_erase_poll_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && busy_o && !prog_q) |=> (rd_data_o[POLL_BIT] == 1'b0));
  assert_toggle_seq_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && busy_o) |=> (rd_data_o[TGL_BIT] == $past(exp_tgl)));
  assert_idle_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !busy_o) |=> (rd_data_o == $past(arr_data_i)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind wip_responder wip_responder_chk #(
  .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT),
  .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .wdata_i(wdata_i),
  .rd_en_i(rd_en_i), .arr_data_i(arr_data_i), .busy_o(busy_o), .rd_data_o(rd_data_o)
);

// File: tb/wip_responder_tb_top.sv
module wip_responder_tb_top;
  localparam int DW = 16, PC = 20, SC = 60, BC = 80, CC = 150;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0, rd = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [DW-1:0] wdata = '0, arr = '0;
  logic          busy;
  logic [DW-1:0] rdd;

  wip_responder #(.DATA_W(DW), .POLL_BIT(7), .TGL_BIT(6),
    .PROG_CYC(PC), .SECT_CYC(SC), .BLK_CYC(BC), .CHIP_CYC(CC)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .wdata_i(wdata),
    .rd_en_i(rd), .arr_data_i(arr), .busy_o(busy), .rd_data_o(rdd));

  always #5 clk = ~clk;

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string req = "R1";
  bit    chk_on = 0;

  // behavioural reference
  bit            m_busy, m_tgl, m_prog;
  int            m_rem;
  logic [DW-1:0] m_wd, m_rd;

  function automatic int dur_of(input logic [1:0] o);
    case (o)
      2'd0: return PC;
      2'd1: return SC;
      2'd2: return BC;
      default: return CC;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_tgl = 0; m_prog = 0; m_rem = 0; m_wd = '0; m_rd = '0;
    end else begin
      if (rd) begin
        if (m_busy) begin
          m_rd    = m_prog ? (m_wd ^ 16'h0080) : '0;
          m_rd[6] = m_tgl;
          m_tgl   = !m_tgl;
        end else m_rd = arr;
      end
      if (m_busy) begin
        if (m_rem == 0) m_busy = 0; else m_rem--;
      end else if (start) begin
        m_busy = 1; m_rem = dur_of(op) - 1; m_tgl = 0;
        m_prog = (op == 2'd0); m_wd = wdata;
      end
    end
  end

  task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", r, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check({req, " busy (R2)"}, DW'(busy), DW'(m_busy));
    check({req, " rd_data (R8)"}, rdd, m_rd);
  end

  always @(posedge clk) if (cyc > 100000) begin
    n_bad++;
    $display("FAIL watchdog: run did not end");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse(input logic [DW-1:0] a);
    @(negedge clk); rd = 1; arr = a;
    @(negedge clk); rd = 0; arr = ~a;
  endtask

  task automatic launch(input logic [1:0] o, input logic [DW-1:0] d);
    @(negedge clk); start = 1; op = o; wdata = d;
    @(negedge clk); start = 0; wdata = 16'h5A5A;
  endtask

  task automatic wait_idle;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    idle(2);
    chk_on = 1;
    req = "R1";
    check("R1 reset busy", DW'(busy), '0);
    check("R1 reset rd_data", rdd, '0);
    rst = 0;

    req = "R7"; rd_pulse(16'h1357); rd_pulse(16'hFFFF); idle(2);

    // program, bit7 of data = 1
    req = "R4"; launch(2'd0, 16'h00A5);
    rd_pulse(16'hFFFF); rd_pulse(16'h0000);
    @(negedge clk); rd = 1; arr = 16'h1111; idle(3); rd = 0;
    req = "R6"; idle(5); rd_pulse(16'h2222);
    req = "R7"; wait_idle; rd_pulse(16'h00A5); rd_pulse(16'h00A5);

    // program, bit7 of data = 0
    req = "R4"; launch(2'd0, 16'h3412); rd_pulse(16'h0); rd_pulse(16'h0);
    req = "R2"; wait_idle; idle(2);

    req = "R5"; launch(2'd1, 16'hFFFF); rd_pulse(16'h1234); idle(4); rd_pulse(16'h4321);
    wait_idle; req = "R7"; rd_pulse(16'hFFFF);
    req = "R5"; launch(2'd2, 16'h0080); rd_pulse(16'h0); rd_pulse(16'h0); wait_idle;
    req = "R5"; launch(2'd3, 16'h00FF); rd_pulse(16'h0);
    @(negedge clk); rd = 1; idle(6); rd = 0;
    wait_idle;

    // relaunch while busy must be ignored
    req = "R3"; launch(2'd0, 16'h0080); idle(5);
    launch(2'd3, 16'hFFFF); rd_pulse(16'h0);
    idle(10); rd_pulse(16'h0);
    wait_idle; rd_pulse(16'hCAFE);

    // read straddling the end of an operation
    req = "R7"; launch(2'd0, 16'h00C3);
    while (m_busy && m_rem > 0) @(negedge clk);
    rd = 1; arr = 16'hBEEF; idle(3); rd = 0;

    // launch and read in the same idle cycle
    req = "R6"; @(negedge clk); start = 1; op = 2'd1; rd = 1; arr = 16'h0F0F;
    @(negedge clk); start = 0; rd_pulse(16'h0); rd_pulse(16'h0);
    wait_idle; idle(3);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule